// File: doc/BRIEF.md
# Software Write Action Field Unit

This block holds one software-writable field that lives inside a register possibly wider than the bus. It works out the field's next value from its present value, the bus write data and the per-bit write enables, according to one of seven write behaviours picked by a static mode input. The modes are a masked write, plus set, clear or toggle driven either by written ones or by written zeros.

A wide register is reached as several bus-width subwords. A field never straddles two of them. The unit therefore works out at elaboration which subword holds its field and where the field sits inside it. It reacts only to a write aimed at that subword, and it lifts the data and enable bits from the matching lanes of the bus. If the field is declared in reversed bit order, the lifted lanes are mirrored before use.

Each qualifying write raises a load enable in that same cycle. The stored value changes at the closing clock edge. An asynchronous active-low reset loads a parameterised value.

Top module: `fieldWriteUnit`

## Requirements
- R1: While and after reset, fieldValue equals RESET_VAL (default 8'hA5) and loadEn is low with no request.
- R2: Mode code 0 (masked write) gives next = (cur & ~en) | (data & en), where data and en are the field's lanes of wrData and wrBitEn.
- R3: The field occupies register bits FIELD_HI..FIELD_LO (default 43..36). Its subword index is FIELD_LO / BUS_W (default 2), and its lanes are bus bits starting at FIELD_LO - index*BUS_W (default bits 11..4).
- R4: loadEn is high in the same cycle only when reqValid is high, reqIsWrite is high and reqSubword equals the field's subword index. Otherwise fieldValue holds.
- R5: Code 1 gives cur | (data & en). Code 4 gives cur | (~data & en).
- R6: Code 2 gives cur & ~(data & en). Code 5 gives cur & (data | ~en).
- R7: Code 3 gives cur ^ (data & en). Code 6 gives cur ^ (~data & en).
- R8: The unused code 7 behaves exactly like code 0.
- R9: With REVERSED=1, field bit i takes lane bit FIELD_W-1-i of both the data and the enables.
- R10: An active reset wins over a qualifying write in the same cycle.
- R11: A loaded value appears on fieldValue after the clock edge that ends the cycle in which loadEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request present |
| reqIsWrite | input | 1 | Request is a write |
| reqSubword | input | IDX_W (2) | Subword index addressed by the request |
| wrData | input | BUS_W (16) | Bus write data |
| wrBitEn | input | BUS_W (16) | Per-bit write enables |
| modeSel | input | 3 | Write action code |
| fieldValue | output | FIELD_W (8) | Stored field value |
| loadEn | output | 1 | Field loads at the next edge |

## Verification
Reset and a qualifying software write can land in the same cycle. The bench holds rstN low while it drives a full-enable write to the field's subword, so both act on that clock edge. It then judges that fieldValue still shows the reset value after the edge and after reset releases. Separately, the same write is aimed at a neighbouring subword and issued as a read, to show that only the exact subword write moves the field.

// File: rtl/fieldwr_pkg.sv
package fieldwr_pkg;

  typedef enum logic [2:0] {
    MODE_PLAIN = 3'd0,
    MODE_SET1  = 3'd1,
    MODE_CLR1  = 3'd2,
    MODE_TGL1  = 3'd3,
    MODE_SET0  = 3'd4,
    MODE_CLR0  = 3'd5,
    MODE_TGL0  = 3'd6
  } fieldMode_e;

  typedef struct packed {
    logic       load;
    fieldMode_e mode;
  } fieldCtl_t;

endpackage

// File: rtl/fieldwrCtrl.sv
module fieldwrCtrl
  import fieldwr_pkg::*;
#(
  parameter int IDX_W      = 2,
  parameter int FIELD_SUBW = 2
) (
  input  logic             reqValid,
  input  logic             reqIsWrite,
  input  logic [IDX_W-1:0] reqSubword,
  input  logic [2:0]       modeSel,
  output fieldCtl_t        ctl
);

  localparam logic [IDX_W-1:0] OWN_SUBW = IDX_W'(FIELD_SUBW);

  logic subwordHit;
  assign subwordHit = (reqSubword == OWN_SUBW);

  // Code 7 has no behaviour of its own and falls back to the masked write.
  always_comb begin
    ctl.load = reqValid && reqIsWrite && subwordHit;
    case (modeSel)
      3'd1:    ctl.mode = MODE_SET1;
      3'd2:    ctl.mode = MODE_CLR1;
      3'd3:    ctl.mode = MODE_TGL1;
      3'd4:    ctl.mode = MODE_SET0;
      3'd5:    ctl.mode = MODE_CLR0;
      3'd6:    ctl.mode = MODE_TGL0;
      default: ctl.mode = MODE_PLAIN;
    endcase
  end

endmodule

// File: rtl/fieldwrData.sv
module fieldwrData
  import fieldwr_pkg::*;
#(
  parameter int              BUS_W     = 16,
  parameter int              FIELD_W   = 8,
  parameter int              SLICE_LO  = 4,
  parameter bit              REVERSED  = 1'b0,
  parameter logic [FIELD_W-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fieldCtl_t          ctl,
  input  logic [BUS_W-1:0]   wrData,
  input  logic [BUS_W-1:0]   wrBitEn,
  output logic [FIELD_W-1:0] fieldQ
);

  logic [FIELD_W-1:0] laneData, laneEn;
  logic [FIELD_W-1:0] sliceData, sliceEn;
  logic [FIELD_W-1:0] nextVal;

  assign laneData = wrData[SLICE_LO +: FIELD_W];
  assign laneEn   = wrBitEn[SLICE_LO +: FIELD_W];

  // Lanes outside the field are intentionally ignored.
  logic unusedLanes;
  assign unusedLanes = ^{wrData, wrBitEn};

  generate
    if (REVERSED) begin : genMirror
      for (genvar b = 0; b < FIELD_W; b++) begin : genBit
        assign sliceData[b] = laneData[FIELD_W-1-b];
        assign sliceEn[b]   = laneEn[FIELD_W-1-b];
      end
    end else begin : genStraight
      assign sliceData = laneData;
      assign sliceEn   = laneEn;
    end
  endgenerate

  always_comb begin
    case (ctl.mode)
      MODE_SET1: nextVal = fieldQ | (sliceData & sliceEn);
      MODE_CLR1: nextVal = fieldQ & ~(sliceData & sliceEn);
      MODE_TGL1: nextVal = fieldQ ^ (sliceData & sliceEn);
      MODE_SET0: nextVal = fieldQ | (~sliceData & sliceEn);
      MODE_CLR0: nextVal = fieldQ & (sliceData | ~sliceEn);
      MODE_TGL0: nextVal = fieldQ ^ (~sliceData & sliceEn);
      default:   nextVal = (fieldQ & ~sliceEn) | (sliceData & sliceEn);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         fieldQ <= RESET_VAL;
    else if (ctl.load) fieldQ <= nextVal;
  end

  // R4: no load from the control side means the stored field stays put.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> fieldQ == $past(fieldQ));

  // R5: set modes never clear a bit.
  assert_no_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && (ctl.mode == MODE_SET1 || ctl.mode == MODE_SET0))
      |=> (fieldQ & $past(fieldQ)) == $past(fieldQ));

  // R6: clear modes never set a bit.
  assert_no_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && (ctl.mode == MODE_CLR1 || ctl.mode == MODE_CLR0))
      |=> (fieldQ | $past(fieldQ)) == $past(fieldQ));

  // R7: toggle modes flip no more bits than are enabled.
  assert_toggle_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && (ctl.mode == MODE_TGL1 || ctl.mode == MODE_TGL0))
      |=> $countones(fieldQ ^ $past(fieldQ)) <= $countones($past(sliceEn)));

  // R2: a masked write with no enabled lane leaves the field unchanged.
  assert_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.mode == MODE_PLAIN && sliceEn == '0)
      |=> fieldQ == $past(fieldQ));

endmodule

// File: rtl/fieldWriteUnit.sv
module fieldWriteUnit
  import fieldwr_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int REG_W    = 64,
  parameter int FIELD_LO = 36,
  parameter int FIELD_HI = 43,
  parameter bit REVERSED = 1'b0,
  parameter logic [FIELD_HI-FIELD_LO:0] RESET_VAL = 8'hA5,
  localparam int FIELD_W  = FIELD_HI - FIELD_LO + 1,
  localparam int SUBW_CNT = REG_W / BUS_W,
  localparam int IDX_W    = (SUBW_CNT > 1) ? $clog2(SUBW_CNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqIsWrite,
  input  logic [IDX_W-1:0]   reqSubword,
  input  logic [BUS_W-1:0]   wrData,
  input  logic [BUS_W-1:0]   wrBitEn,
  input  logic [2:0]         modeSel,
  output logic [FIELD_W-1:0] fieldValue,
  output logic               loadEn
);

  // The field sits wholly inside one subword.
  localparam int FIELD_SUBW = FIELD_LO / BUS_W;
  localparam int SLICE_LO   = FIELD_LO - FIELD_SUBW * BUS_W;

  fieldCtl_t ctl;

  fieldwrCtrl #(
    .IDX_W      (IDX_W),
    .FIELD_SUBW (FIELD_SUBW)
  ) uCtrl (
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .reqSubword (reqSubword),
    .modeSel    (modeSel),
    .ctl        (ctl)
  );

  fieldwrData #(
    .BUS_W     (BUS_W),
    .FIELD_W   (FIELD_W),
    .SLICE_LO  (SLICE_LO),
    .REVERSED  (REVERSED),
    .RESET_VAL (RESET_VAL)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .wrBitEn (wrBitEn),
    .fieldQ  (fieldValue)
  );

  assign loadEn = ctl.load;

endmodule

// File: tb/sim_fieldWriteUnit.sv
module sim_fieldWriteUnit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsWrite = 1'b0;
  logic [1:0]  reqSubword = '0;
  logic [15:0] wrData = '0;
  logic [15:0] wrBitEn = '0;
  logic [2:0]  modeSel = '0;
  logic [7:0]  fieldValue, fieldValueRev;
  logic        loadEn, loadEnRev;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  fieldWriteUnit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqSubword(reqSubword), .wrData(wrData), .wrBitEn(wrBitEn),
    .modeSel(modeSel), .fieldValue(fieldValue), .loadEn(loadEn)
  );

  fieldWriteUnit #(.REVERSED(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqSubword(reqSubword), .wrData(wrData), .wrBitEn(wrBitEn),
    .modeSel(modeSel), .fieldValue(fieldValueRev), .loadEn(loadEnRev)
  );

  function automatic logic [7:0] applyMode(input logic [2:0] m, input logic [7:0] c,
                                           input logic [7:0] d, input logic [7:0] e);
    case (m)
      3'd1: return c | (d & e);
      3'd2: return c & ~(d & e);
      3'd3: return c ^ (d & e);
      3'd4: return c | (~d & e);
      3'd5: return c & (d | ~e);
      3'd6: return c ^ (~d & e);
      default: return (c & ~e) | (d & e);
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request for one cycle; check loadEn mid-cycle and the field after the edge.
  task automatic request(input string req, input logic [1:0] sub, input logic isWr,
                         input logic [2:0] m, input logic [7:0] d, input logic [7:0] e);
    logic hit;
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = isWr; reqSubword = sub; modeSel = m;
    wrData  = {4'h5, d, 4'hA};
    wrBitEn = {4'hF, e, 4'hF};
    hit = isWr && (sub == 2'd2);
    #1 check({req, " loadEn"}, {15'd0, loadEn}, {15'd0, hit});
    if (hit) model = applyMode(m, model, d, e);
    @(posedge clk); #1;
    check(req, {8'd0, fieldValue}, {8'd0, model});
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset;
    check("R1 value", {8'd0, fieldValue}, 16'h00A5);
    check("R1 loadEn", {15'd0, loadEn}, 16'd0);
    model = 8'hA5;
  endtask

  task automatic testPlain;
    request("R2 R3 R11 full write", 2'd2, 1'b1, 3'd0, 8'h34, 8'hFF);
    request("R2 partial enables",   2'd2, 1'b1, 3'd0, 8'hBC, 8'h0F);
  endtask

  task automatic testQualify;
    request("R4 other subword", 2'd1, 1'b1, 3'd0, 8'h00, 8'hFF);
    request("R4 read request",  2'd2, 1'b0, 3'd0, 8'h00, 8'hFF);
    request("R3 top subword",   2'd3, 1'b1, 3'd0, 8'h00, 8'hFF);
  endtask

  task automatic testSetClear;
    request("R2 preload",   2'd2, 1'b1, 3'd0, 8'h0F, 8'hFF);
    request("R5 set-ones",  2'd2, 1'b1, 3'd1, 8'hF0, 8'h30);
    request("R6 clr-ones",  2'd2, 1'b1, 3'd2, 8'h0F, 8'h05);
    request("R5 set-zeros", 2'd2, 1'b1, 3'd4, 8'h7F, 8'hC0);
    request("R6 clr-zeros", 2'd2, 1'b1, 3'd5, 8'hF0, 8'h3C);
  endtask

  task automatic testToggle;
    request("R7 tgl-ones",  2'd2, 1'b1, 3'd3, 8'hAA, 8'hF0);
    request("R7 tgl-zeros", 2'd2, 1'b1, 3'd6, 8'hAA, 8'h0F);
  endtask

  task automatic testSpareCode;
    request("R8 code 7", 2'd2, 1'b1, 3'd7, 8'h5A, 8'hCC);
  endtask

  task automatic testReversed;
    // u1 mirrors lanes: data 0x01 lands on field bit 7, enable 0x0F covers bits 7..4.
    request("R9 setup", 2'd2, 1'b1, 3'd0, 8'h01, 8'hFF);
    check("R9 mirrored full", {8'd0, fieldValueRev}, 16'h0080);
    request("R9 setup2", 2'd2, 1'b1, 3'd0, 8'h0E, 8'h0F);
    check("R9 mirrored enables", {8'd0, fieldValueRev}, 16'h0070);
  endtask

  task automatic testResetWins;
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b1; reqIsWrite = 1'b1; reqSubword = 2'd2; modeSel = 3'd0;
    wrData = 16'h0000; wrBitEn = 16'hFFFF;
    @(posedge clk); #1;
    check("R10 during reset", {8'd0, fieldValue}, 16'h00A5);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R10 after release", {8'd0, fieldValue}, 16'h00A5);
    model = 8'hA5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {8'd0, fieldValue}, 16'h00A5);
    testPlain();
    testQualify();
    testSetClear();
    testToggle();
    testSpareCode();
    testReversed();
    testResetWins();
    request("R11 post-reset write", 2'd2, 1'b1, 3'd1, 8'h02, 8'h02);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule